// File: doc/BRIEF.md
# Three-State Power Mode Sequencer

This block moves a chip between three operating modes: full-speed operation (run), a clock-stopped state with logic still powered (idle), and a deep state with both clock and logic power removed (sleep). Three single-cycle request inputs ask for idle, for sleep or for a return to run. The block drives a CPU clock-enable, a logic power-enable and a busy flag. It also reports the settled mode and a nominal power figure for that mode in microwatts.

Every transition lasts a set number of clock cycles, and each of these counts is a parameter. Leaving run for idle, or idle for run, is short. Entering sleep is a chain of three equal shutdown steps: the clock is gated when the first step starts, and logic power is removed only once the third step ends. Waking from sleep is the longest transition and has a lower limit of its own. While a transition is under way, busy is high and requests are dropped. The one exception is a wake request that arrives during sleep entry: it is held and served as soon as sleep is reached.

States: ST_RUN, ST_RUN2IDLE (run to idle), ST_IDLE, ST_IDLE2RUN (idle to run), ST_SHUT1, ST_SHUT2 and ST_SHUT3 (sleep entry steps), ST_SLEEP, and ST_WAKE (sleep to run). Transitions: run takes sleep to ST_SHUT1 and idle to ST_RUN2IDLE. Idle takes sleep to ST_SHUT1 and wake to ST_IDLE2RUN. Each timed state moves on when its count expires: ST_RUN2IDLE to idle, ST_IDLE2RUN to run, ST_SHUT1 to ST_SHUT2, ST_SHUT2 to ST_SHUT3, ST_SHUT3 to sleep, and ST_WAKE to run. Sleep goes to ST_WAKE on a wake request or a held wake.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in run mode with cpu_clk_en=1, logic_pwr_en=1, busy=0 and pwr_uw=400000.
- R2: The mode output encodes run=0, idle=1 and sleep=2. The pwr_uw output reads 400000 in run, 50000 in idle and 160 in sleep.
- R3: A req_idle in settled run holds busy high for T_RUN_IDLE cycles and then settles in idle with cpu_clk_en=0 and logic_pwr_en=1.
- R4: A req_wake in settled idle holds busy high for T_IDLE_RUN cycles and then settles in run with both enables high.
- R5: A req_sleep in settled run or settled idle holds busy high for three steps of T_SLEEP_STEP cycles each. During all of them cpu_clk_en=0 and logic_pwr_en=1. When busy falls the block is in sleep with both enables low.
- R6: A req_wake in settled sleep holds busy high for max(T_WAKE, MIN_WAKE) cycles, with logic_pwr_en=1 and cpu_clk_en=0, and then settles in run. cpu_clk_en rises only when run is reached.
- R7: Sleep is left only for run. A req_idle or req_sleep in settled sleep has no effect.
- R8: Any request that arrives while busy is high and the block is not entering sleep has no effect.
- R9: A req_wake during sleep entry is held. Sleep is then shown with busy low for exactly one cycle, after which the wake sequence of R6 starts without a new request.
- R10: In run, req_sleep takes priority over req_idle, and req_wake is ignored. In idle, req_sleep takes priority over req_wake, and req_idle is ignored.
- R11: During a transition, mode and pwr_uw keep showing the source mode. They change only in the cycle in which busy falls. cpu_clk_en is never high while logic_pwr_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_idle | input | 1 | Request to enter idle |
| req_sleep | input | 1 | Request to enter sleep |
| req_wake | input | 1 | Request to return to run |
| cpu_clk_en | output | 1 | CPU clock enable |
| logic_pwr_en | output | 1 | Logic power enable |
| busy | output | 1 | Transition in progress |
| mode | output | 2 | Settled mode code (run=0, idle=1, sleep=2) |
| pwr_uw | output | 19 | Nominal power of the reported mode, in microwatts |

## Verification
Two pairs of events can fall in the same cycle. The first pair is two requests in one settled state. The bench raises req_idle and req_sleep together in run, and req_wake and req_sleep together in idle. It then checks the length of the busy window and the mode reached, which shows which request won. The second pair is a wake request and the sleep shutdown, which overlap when req_wake is pulsed in the middle of sleep entry. Here the bench expects the full shutdown length, then exactly one sample of settled sleep with power removed, then the clamped wake length ending in run.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    localparam int PWR_W = 19;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_SLEEP = 2'd2
    } pmode_e;

    typedef enum logic [3:0] {
        ST_RUN,
        ST_RUN2IDLE,
        ST_IDLE,
        ST_IDLE2RUN,
        ST_SHUT1,
        ST_SHUT2,
        ST_SHUT3,
        ST_SLEEP,
        ST_WAKE
    } pstate_e;

    localparam logic [PWR_W-1:0] PWR_RUN_UW   = 19'd400000;
    localparam logic [PWR_W-1:0] PWR_IDLE_UW  = 19'd50000;
    localparam logic [PWR_W-1:0] PWR_SLEEP_UW = 19'd160;

    function automatic logic [PWR_W-1:0] mode_power(input pmode_e m);
        logic [PWR_W-1:0] p;
        unique case (m)
            MODE_RUN:   p = PWR_RUN_UW;
            MODE_IDLE:  p = PWR_IDLE_UW;
            MODE_SLEEP: p = PWR_SLEEP_UW;
            default:    p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pwr_step_timer.sv
module pwr_step_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
#(
    parameter int          CW        = 8,
    parameter int unsigned RI_CYC    = 10,
    parameter int unsigned IR_CYC    = 10,
    parameter int unsigned STEP_CYC  = 30,
    parameter int unsigned WAKE_CYC  = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_idle,
    input  logic             req_sleep,
    input  logic             req_wake,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CW-1:0]    tmr_val,
    output logic             cpu_clk_en,
    output logic             logic_pwr_en,
    output logic             busy,
    output logic [1:0]       mode,
    output logic [PWR_W-1:0] pwr_uw
);

    pstate_e state, state_n;
    logic    src_idle;
    logic    wake_pend;
    logic    in_shut;
    pmode_e  mode_q;

    assign in_shut = (state == ST_SHUT1) || (state == ST_SHUT2) || (state == ST_SHUT3);

    // State register, with the sleep-entry source and the held wake
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_RUN;
            src_idle  <= 1'b0;
            wake_pend <= 1'b0;
        end else begin
            state <= state_n;
            if (state_n == ST_SHUT1 && state != ST_SHUT1) begin
                src_idle <= (state == ST_IDLE);
            end
            if (state_n == ST_WAKE) begin
                wake_pend <= 1'b0;
            end else if (in_shut && req_wake) begin
                wake_pend <= 1'b1;
            end
        end
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_RUN: begin
                if (req_sleep)     state_n = ST_SHUT1;
                else if (req_idle) state_n = ST_RUN2IDLE;
            end
            ST_RUN2IDLE: if (tmr_done) state_n = ST_IDLE;
            ST_IDLE: begin
                if (req_sleep)     state_n = ST_SHUT1;
                else if (req_wake) state_n = ST_IDLE2RUN;
            end
            ST_IDLE2RUN: if (tmr_done) state_n = ST_RUN;
            ST_SHUT1:    if (tmr_done) state_n = ST_SHUT2;
            ST_SHUT2:    if (tmr_done) state_n = ST_SHUT3;
            ST_SHUT3:    if (tmr_done) state_n = ST_SLEEP;
            ST_SLEEP:    if (req_wake || wake_pend) state_n = ST_WAKE;
            ST_WAKE:     if (tmr_done) state_n = ST_RUN;
            default:     state_n = ST_RUN;
        endcase
    end

    // Timer load on entry to each timed state
    always_comb begin
        tmr_val = '0;
        unique case (state_n)
            ST_RUN2IDLE:                  tmr_val = CW'(RI_CYC - 1);
            ST_IDLE2RUN:                  tmr_val = CW'(IR_CYC - 1);
            ST_SHUT1, ST_SHUT2, ST_SHUT3: tmr_val = CW'(STEP_CYC - 1);
            ST_WAKE:                      tmr_val = CW'(WAKE_CYC - 1);
            default:                      tmr_val = '0;
        endcase
        tmr_load = (state_n != state) &&
                   (state_n != ST_RUN) && (state_n != ST_IDLE) && (state_n != ST_SLEEP);
    end

    // Outputs
    always_comb begin
        cpu_clk_en   = 1'b0;
        logic_pwr_en = 1'b1;
        busy         = 1'b1;
        mode_q       = MODE_RUN;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                busy       = 1'b0;
            end
            ST_RUN2IDLE: cpu_clk_en = 1'b1;
            ST_IDLE: begin
                busy   = 1'b0;
                mode_q = MODE_IDLE;
            end
            ST_IDLE2RUN: mode_q = MODE_IDLE;
            ST_SHUT1, ST_SHUT2, ST_SHUT3: mode_q = src_idle ? MODE_IDLE : MODE_RUN;
            ST_SLEEP: begin
                logic_pwr_en = 1'b0;
                busy         = 1'b0;
                mode_q       = MODE_SLEEP;
            end
            ST_WAKE: mode_q = MODE_SLEEP;
            default: mode_q = MODE_RUN;
        endcase
        mode   = mode_q;
        pwr_uw = mode_power(mode_q);
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int unsigned T_RUN_IDLE   = 10,
    parameter int unsigned T_IDLE_RUN   = 10,
    parameter int unsigned T_SLEEP_STEP = 30,
    parameter int unsigned T_WAKE       = 160,
    parameter int unsigned MIN_WAKE     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_idle,
    input  logic             req_sleep,
    input  logic             req_wake,
    output logic             cpu_clk_en,
    output logic             logic_pwr_en,
    output logic             busy,
    output logic [1:0]       mode,
    output logic [PWR_W-1:0] pwr_uw
);

    localparam int unsigned WAKE_CYC = (T_WAKE < MIN_WAKE) ? MIN_WAKE : T_WAKE;
    localparam int unsigned MAX_A    = (T_RUN_IDLE > T_IDLE_RUN) ? T_RUN_IDLE : T_IDLE_RUN;
    localparam int unsigned MAX_B    = (T_SLEEP_STEP > WAKE_CYC) ? T_SLEEP_STEP : WAKE_CYC;
    localparam int unsigned MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int          CW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic          tmr_load;
    logic          tmr_done;
    logic [CW-1:0] tmr_val;

    pwr_step_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    pwr_mode_fsm #(
        .CW       (CW),
        .RI_CYC   (T_RUN_IDLE),
        .IR_CYC   (T_IDLE_RUN),
        .STEP_CYC (T_SLEEP_STEP),
        .WAKE_CYC (WAKE_CYC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_idle     (req_idle),
        .req_sleep    (req_sleep),
        .req_wake     (req_wake),
        .tmr_done     (tmr_done),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .cpu_clk_en   (cpu_clk_en),
        .logic_pwr_en (logic_pwr_en),
        .busy         (busy),
        .mode         (mode),
        .pwr_uw       (pwr_uw)
    );

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_clk_en,
    input logic        logic_pwr_en,
    input logic        busy,
    input logic [1:0]  mode,
    input logic [18:0] pwr_uw
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_run_rails_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 && !busy) |-> (cpu_clk_en && logic_pwr_en));

    assert_code_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> (pwr_uw == 19'd400000));

    assert_code_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (pwr_uw == 19'd50000));

    assert_code_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (pwr_uw == 19'd160));

    assert_idle_rails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !busy) |-> (!cpu_clk_en && logic_pwr_en));

    assert_sleep_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !busy) |-> (!cpu_clk_en && !logic_pwr_en));

    assert_power_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $fell(logic_pwr_en)) |-> ($fell(busy) && mode == 2'd2));

    assert_clk_only_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(cpu_clk_en)) |-> (mode == 2'd0));

    assert_sleep_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode) == 2'd2 && mode != 2'd2) |-> (mode == 2'd0));

    assert_mode_at_busy_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && mode != $past(mode)) |-> ($past(busy) && !busy));

    assert_clk_needs_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !logic_pwr_en |-> !cpu_clk_en);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_clk_en   (cpu_clk_en),
    .logic_pwr_en (logic_pwr_en),
    .busy         (busy),
    .mode         (mode),
    .pwr_uw       (pwr_uw)
);

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;

    localparam int RI   = 3;
    localparam int IR   = 4;
    localparam int STEP = 5;
    localparam int WK   = 2;
    localparam int MINW = 10;
    localparam int SHUT_N = 3 * STEP;
    localparam int WAKE_N = (WK < MINW) ? MINW : WK;

    // {req[1:0] (1=idle,2=sleep,3=wake), busy cycles[7:0], mode[1:0], clk_en, pwr_en}
    localparam int NV = 11;
    localparam logic [13:0] VEC [NV] = '{
        {2'd1, 8'(RI),     2'd1, 1'b0, 1'b1},
        {2'd3, 8'(IR),     2'd0, 1'b1, 1'b1},
        {2'd2, 8'(SHUT_N), 2'd2, 1'b0, 1'b0},
        {2'd1, 8'd0,       2'd2, 1'b0, 1'b0},
        {2'd2, 8'd0,       2'd2, 1'b0, 1'b0},
        {2'd3, 8'(WAKE_N), 2'd0, 1'b1, 1'b1},
        {2'd3, 8'd0,       2'd0, 1'b1, 1'b1},
        {2'd1, 8'(RI),     2'd1, 1'b0, 1'b1},
        {2'd1, 8'd0,       2'd1, 1'b0, 1'b1},
        {2'd2, 8'(SHUT_N), 2'd2, 1'b0, 1'b0},
        {2'd3, 8'(WAKE_N), 2'd0, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_idle = 1'b0, req_sleep = 1'b0, req_wake = 1'b0;
    logic        cpu_clk_en, logic_pwr_en, busy;
    logic [1:0]  mode;
    logic [18:0] pwr_uw;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl #(
        .T_RUN_IDLE   (RI),
        .T_IDLE_RUN   (IR),
        .T_SLEEP_STEP (STEP),
        .T_WAKE       (WK),
        .MIN_WAKE     (MINW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_idle     (req_idle),
        .req_sleep    (req_sleep),
        .req_wake     (req_wake),
        .cpu_clk_en   (cpu_clk_en),
        .logic_pwr_en (logic_pwr_en),
        .busy         (busy),
        .mode         (mode),
        .pwr_uw       (pwr_uw)
    );

    function automatic int exp_code(input logic [1:0] m);
        if (m == 2'd0) return 400000;
        if (m == 2'd1) return 50000;
        return 160;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_settled(input string tag, input logic [1:0] m,
                               input logic ce, input logic pe);
        chk({tag, " busy"},   int'(busy), 0);
        chk({tag, " mode"},   int'(mode), int'(m));
        chk({tag, " clk_en"}, int'(cpu_clk_en), int'(ce));
        chk({tag, " pwr_en"}, int'(logic_pwr_en), int'(pe));
        chk("R2 power code", int'(pwr_uw), exp_code(m));
    endtask

    // Pulse a request for one cycle; returns at the first sample after capture
    task automatic pulse(input logic [1:0] r);
        @(negedge clk);
        req_idle  = (r == 2'd1);
        req_sleep = (r == 2'd2);
        req_wake  = (r == 2'd3);
        @(negedge clk);
        req_idle  = 1'b0;
        req_sleep = 1'b0;
        req_wake  = 1'b0;
    endtask

    // Counts busy samples from the current one; R11 invariant checked each sample
    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            chk("R11 clk_en without power", int'(cpu_clk_en && !logic_pwr_en), 0);
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_settled("R1 reset", 2'd0, 1'b1, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk_settled("R1 after release", 2'd0, 1'b1, 1'b1);

        // Vector walk: R3 R4 R5 R6 R7 R10
        for (int i = 0; i < NV; i++) begin
            pulse(VEC[i][13:12]);
            count_busy(n);
            chk($sformatf("R3/R4/R5/R6/R7/R10 vector %0d busy length", i), n, int'(VEC[i][11:4]));
            chk_settled($sformatf("R3/R4/R5/R6/R7/R10 vector %0d", i),
                        VEC[i][3:2], VEC[i][1], VEC[i][0]);
        end

        // R10: idle and sleep together in run -> sleep wins
        @(negedge clk);
        req_idle = 1'b1; req_sleep = 1'b1;
        @(negedge clk);
        req_idle = 1'b0; req_sleep = 1'b0;
        count_busy(n);
        chk("R10 run sleep beats idle length", n, SHUT_N);
        chk_settled("R10 run sleep beats idle", 2'd2, 1'b0, 1'b0);
        pulse(2'd3);
        count_busy(n);
        chk("R6 wake length", n, WAKE_N);

        // R10: wake and sleep together in idle -> sleep wins
        pulse(2'd1);
        count_busy(n);
        @(negedge clk);
        req_wake = 1'b1; req_sleep = 1'b1;
        @(negedge clk);
        req_wake = 1'b0; req_sleep = 1'b0;
        // R5 / R11: first shutdown sample shows idle source, clock off, power on
        chk("R11 source mode during shutdown", int'(mode), 1);
        chk("R5 clk_en low in step", int'(cpu_clk_en), 0);
        chk("R5 pwr_en high in step", int'(logic_pwr_en), 1);
        count_busy(n);
        chk("R10 idle sleep beats wake length", n, SHUT_N);
        chk_settled("R10 idle sleep beats wake", 2'd2, 1'b0, 1'b0);
        pulse(2'd3);
        count_busy(n);

        // R8: sleep request during run-to-idle ignored
        pulse(2'd1);
        req_sleep = 1'b1;
        @(negedge clk);
        req_sleep = 1'b0;
        count_busy(n);
        chk("R8 remaining busy after ignored request", n, RI - 1);
        chk_settled("R8 request ignored", 2'd1, 1'b0, 1'b1);
        @(negedge clk);
        chk_settled("R8 still idle", 2'd1, 1'b0, 1'b1);
        pulse(2'd3);
        count_busy(n);

        // R9: wake during sleep entry is held
        pulse(2'd2);
        chk("R11 source mode run during shutdown", int'(mode), 0);
        req_wake = 1'b1;
        @(negedge clk);
        req_wake = 1'b0;
        count_busy(n);
        chk("R9 shutdown completes", n, SHUT_N - 1);
        chk_settled("R9 one sleep cycle", 2'd2, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 wake starts alone", int'(busy), 1);
        chk("R6 power on during wake", int'(logic_pwr_en), 1);
        chk("R6 clock off during wake", int'(cpu_clk_en), 0);
        count_busy(n);
        chk("R9 wake length", n, WAKE_N);
        chk_settled("R9 back in run", 2'd0, 1'b1, 1'b1);

        // R1: reset in the middle of a wake
        pulse(2'd2);
        count_busy(n);
        pulse(2'd3);
        rst_n = 1'b0;
        @(negedge clk);
        chk_settled("R1 reset mid-wake", 2'd0, 1'b1, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_settled("R1 stays run after reset", 2'd0, 1'b1, 1'b1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule